// File: doc/BRIEF.md
# Segment lookaside buffer

The block turns a 64-bit effective address into an 80-bit virtual address at segment granularity. Segments are 256 MB, so the upper 36 bits of the effective address form the effective segment ID (ESID). The low 28 bits pass through unchanged as the offset. A fully associative table of 32 slots holds ESID to VSID pairs. A hit replaces the ESID with the stored 52-bit virtual segment ID (VSID), and the result is registered one cycle after the request.

The table is filled only by software. A write names a slot and supplies both the ESID and the VSID. If a lookup finds no valid match, the block raises a segment-fault output and does not fill the table itself, so that the fault handler can install the entry. On a context switch a single flush command drops every valid bit at once.

Top module: `slb_top`

## Requirements
- R1: After reset every slot is invalid, so each lookup misses, and rsp_valid, rsp_hit, seg_fault and rsp_va are all 0 while no lookup has been made.
- R2: A lookup asserted in one cycle produces its response in the next cycle, where rsp_valid is 1. In a cycle that follows no lookup, rsp_valid, rsp_hit, seg_fault and rsp_va are 0.
- R3: A lookup hits when a valid slot holds ESID equal to lkp_ea[63:28]. The response then has rsp_hit=1, seg_fault=0 and rsp_va = {stored VSID, lkp_ea[27:0]}.
- R4: A lookup that hits no valid slot responds with rsp_hit=0, seg_fault=1 and rsp_va=0. The table is left unchanged, so repeating the same lookup misses again.
- R5: A write with wr_en=1 stores wr_esid and wr_vsid in slot wr_slot and marks that slot valid. It replaces whatever the slot held before.
- R6: A write whose ESID already matches a valid slot other than wr_slot invalidates that other slot, so that at most one valid slot ever matches any ESID.
- R7: A flush clears the valid bit of every slot in one cycle.
- R8: A lookup made in the same cycle as a flush reports a miss, even if a matching slot was valid.
- R9: A write made in the same cycle as a flush has no effect: the flush wins and the slot stays invalid.
- R10: A lookup made in the same cycle as a write sees the table as it was before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lkp_valid | input | 1 | Lookup request this cycle |
| lkp_ea | input | 64 | Effective address to translate |
| wr_en | input | 1 | Software insert strobe |
| wr_slot | input | 5 | Slot index written by the insert |
| wr_esid | input | 36 | Effective segment ID to store |
| wr_vsid | input | 52 | Virtual segment ID to store |
| flush | input | 1 | Invalidate all slots (context switch) |
| rsp_valid | output | 1 | Response for the previous cycle's lookup |
| rsp_hit | output | 1 | Lookup found a valid matching slot |
| rsp_va | output | 80 | Translated virtual address, 0 on a miss |
| seg_fault | output | 1 | Lookup missed; software must insert an entry |

## Verification
The assertions check on every cycle that lookups match at most one slot and that a response follows each request in the next cycle and is absent otherwise. They also check that hit and fault never appear together, that the offset bits pass through on a hit, and that a flush empties the table and forces a miss for a lookup in the same cycle. Only the bench's scenarios can show which VSID should come back: this covers overwrites of a slot, duplicate inserts that move an ESID to another slot, a write dropped by a simultaneous flush, and a lookup that must see the table as it stood before a write in the same cycle. A behavioural reference table in the bench predicts every response and is compared against the outputs each clock.

// File: rtl/slb_pkg.sv
package slb_pkg;

    // Architectural widths of the segment translation
    localparam int EA_W     = 64;
    localparam int OFF_W    = 28;
    localparam int VSID_W   = 52;
    localparam int ESID_W   = EA_W - OFF_W;
    localparam int VA_W     = VSID_W + OFF_W;

    typedef struct packed {
        logic              vld;
        logic [ESID_W-1:0] esid;
        logic [VSID_W-1:0] vsid;
    } seg_entry_t;

endpackage

// File: rtl/slb_cam.sv
module slb_cam
    import slb_pkg::*;
#(
    parameter int N = 32
) (
    input  seg_entry_t [N-1:0] tbl_i,
    input  logic [ESID_W-1:0]  key_i,
    output logic [N-1:0]       match_o
);

    // One comparator per slot; an invalid slot never matches
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match_o[g] = tbl_i[g].vld && (tbl_i[g].esid == key_i);
    end

endmodule

// File: rtl/slb_enc.sv
module slb_enc #(
    parameter int N     = 32,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     vec_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             any_o
);

    // OR-based encoder: correct because the vector is at most one-hot
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (vec_i[i]) begin
                idx_o = idx_o | IDX_W'(i);
            end
        end
    end

    assign any_o = |vec_i;

endmodule

// File: rtl/slb_top.sv
module slb_top
    import slb_pkg::*;
#(
    parameter int NUM_ENTRIES = 32,
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lkp_valid,
    input  logic [EA_W-1:0]     lkp_ea,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_slot,
    input  logic [ESID_W-1:0]   wr_esid,
    input  logic [VSID_W-1:0]   wr_vsid,
    input  logic                flush,
    output logic                rsp_valid,
    output logic                rsp_hit,
    output logic [VA_W-1:0]     rsp_va,
    output logic                seg_fault
);

    typedef struct packed {
        seg_entry_t [NUM_ENTRIES-1:0] tbl;
        logic                         rsp_vld;
        logic                         rsp_hit;
        logic                         rsp_flt;
        logic [VA_W-1:0]              rsp_va;
    } slb_state_t;

    slb_state_t st_d, st_q;

    logic [NUM_ENTRIES-1:0] lkp_match;
    logic [NUM_ENTRIES-1:0] wr_match;
    logic [IDX_W-1:0]       lkp_idx;
    logic                   lkp_any;
    logic [ESID_W-1:0]      lkp_esid;
    logic [VSID_W-1:0]      lkp_vsid;
    logic                   lkp_hit;

    assign lkp_esid = lkp_ea[EA_W-1:OFF_W];

    slb_cam #(.N(NUM_ENTRIES)) i_cam_lkp (
        .tbl_i   (st_q.tbl),
        .key_i   (lkp_esid),
        .match_o (lkp_match)
    );

    slb_cam #(.N(NUM_ENTRIES)) i_cam_wr (
        .tbl_i   (st_q.tbl),
        .key_i   (wr_esid),
        .match_o (wr_match)
    );

    slb_enc #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) i_enc (
        .vec_i (lkp_match),
        .idx_o (lkp_idx),
        .any_o (lkp_any)
    );

    assign lkp_vsid = st_q.tbl[lkp_idx].vsid;
    assign lkp_hit  = lkp_valid && !flush && lkp_any;

    always_comb begin
        st_d = st_q;

        // Response path: based on the table before this cycle's update
        st_d.rsp_vld = lkp_valid;
        st_d.rsp_hit = lkp_hit;
        st_d.rsp_flt = lkp_valid && !lkp_hit;
        st_d.rsp_va  = lkp_hit ? {lkp_vsid, lkp_ea[OFF_W-1:0]} : '0;

        // Table update: flush wins over an insert
        if (flush) begin
            for (int i = 0; i < NUM_ENTRIES; i++) begin
                st_d.tbl[i].vld = 1'b0;
            end
        end else if (wr_en) begin
            for (int i = 0; i < NUM_ENTRIES; i++) begin
                if (wr_match[i] && (IDX_W'(i) != wr_slot)) begin
                    st_d.tbl[i].vld = 1'b0;
                end
            end
            st_d.tbl[wr_slot].vld  = 1'b1;
            st_d.tbl[wr_slot].esid = wr_esid;
            st_d.tbl[wr_slot].vsid = wr_vsid;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.rsp_vld;
    assign rsp_hit   = st_q.rsp_hit;
    assign seg_fault = st_q.rsp_flt;
    assign rsp_va    = st_q.rsp_va;

    // ------------------------------------------------------------------
    // Assertions
    // ------------------------------------------------------------------
    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lkp_match)); // R6

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        lkp_valid |=> rsp_valid); // R2

    AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !lkp_valid |=> (!rsp_valid && !rsp_hit && !seg_fault && rsp_va == '0)); // R2

    AST_HIT_XOR_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_hit != seg_fault)); // R4

    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (lkp_valid && lkp_hit) |=> (rsp_va[OFF_W-1:0] == $past(lkp_ea[OFF_W-1:0]))); // R3

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (lkp_match == '0 && wr_match == '0)); // R7

    AST_FLUSH_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (lkp_valid && flush) |=> (seg_fault && !rsp_hit)); // R8

    AST_WRITE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !flush) |=> st_q.tbl[$past(wr_slot)].vld); // R5

endmodule

// File: tb/test_slb_top.sv
module test_slb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lkp_valid = 1'b0;
    logic [63:0] lkp_ea = '0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_slot = '0;
    logic [35:0] wr_esid = '0;
    logic [51:0] wr_vsid = '0;
    logic        flush = 1'b0;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [79:0] rsp_va;
    logic        seg_fault;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    string cur_tag = "R1";

    // Reference table
    bit          m_vld [32];
    logic [35:0] m_esid[32];
    logic [51:0] m_vsid[32];

    logic        e_vld, e_hit, e_flt;
    logic [79:0] e_va;

    always #4 clk = ~clk;

    slb_top i_slb_top (
        .clk(clk), .rst_n(rst_n), .lkp_valid(lkp_valid), .lkp_ea(lkp_ea),
        .wr_en(wr_en), .wr_slot(wr_slot), .wr_esid(wr_esid), .wr_vsid(wr_vsid),
        .flush(flush), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_va(rsp_va), .seg_fault(seg_fault)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            bad++;
            total++;
            $display("FAIL watchdog: run hung, got cycles=%0d expected <100000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic model_step();
        int hit_i = -1;
        for (int i = 0; i < 32; i++)
            if (m_vld[i] && m_esid[i] == lkp_ea[63:28]) hit_i = i;
        e_vld = lkp_valid;
        e_hit = lkp_valid && !flush && hit_i >= 0;
        e_flt = lkp_valid && !e_hit;
        e_va  = e_hit ? {m_vsid[hit_i], lkp_ea[27:0]} : 80'h0;
        if (flush) begin
            for (int i = 0; i < 32; i++) m_vld[i] = 1'b0;
        end else if (wr_en) begin
            for (int i = 0; i < 32; i++)
                if (i != int'(wr_slot) && m_vld[i] && m_esid[i] == wr_esid) m_vld[i] = 1'b0;
            m_vld[wr_slot]  = 1'b1;
            m_esid[wr_slot] = wr_esid;
            m_vsid[wr_slot] = wr_vsid;
        end
    endtask

    // Apply current inputs for one clock, then compare away from the edge
    task automatic cyc();
        @(posedge clk);
        model_step();
        #2;
        total++;
        if ({rsp_valid, rsp_hit, seg_fault, rsp_va} !== {e_vld, e_hit, e_flt, e_va}) begin
            bad++;
            $display("FAIL %s: got v=%0b h=%0b f=%0b va=%h expected v=%0b h=%0b f=%0b va=%h",
                     cur_tag, rsp_valid, rsp_hit, seg_fault, rsp_va, e_vld, e_hit, e_flt, e_va);
        end
        lkp_valid = 1'b0; wr_en = 1'b0; flush = 1'b0;
    endtask

    task automatic do_wr(input logic [4:0] s, input logic [35:0] es, input logic [51:0] vs);
        wr_en = 1'b1; wr_slot = s; wr_esid = es; wr_vsid = vs;
    endtask

    task automatic do_lkp(input logic [35:0] es, input logic [27:0] off);
        lkp_valid = 1'b1; lkp_ea = {es, off};
    endtask

    initial begin
        for (int i = 0; i < 32; i++) begin
            m_vld[i] = 1'b0; m_esid[i] = '0; m_vsid[i] = '0;
        end
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1: idle outputs and empty table
        cur_tag = "R1"; cyc();
        do_lkp(36'h0, 28'h0); cyc();
        do_lkp(36'h123456789, 28'hABCDEF0); cyc();

        // R5 / R3: inserts at boundary slots, then hits
        cur_tag = "R5"; do_wr(5'd0, 36'h000000001, 52'hA_BCDE_F012_3456); cyc();
        do_wr(5'd31, 36'hFFFFFFFFF, 52'hF_FFFF_FFFF_FFFF); cyc();
        do_wr(5'd7, 36'h5A5A5A5A5, 52'h1_2345_6789_ABCD); cyc();
        cur_tag = "R3"; do_lkp(36'h000000001, 28'h0000000); cyc();
        do_lkp(36'hFFFFFFFFF, 28'hFFFFFFF); cyc();
        do_lkp(36'h5A5A5A5A5, 28'h1234567); cyc();
        cur_tag = "R2"; cyc();

        // R4: miss, then no fill
        cur_tag = "R4"; do_lkp(36'h000000002, 28'h5); cyc();
        do_lkp(36'h000000002, 28'h5); cyc();

        // R5: overwrite a slot
        cur_tag = "R5"; do_wr(5'd7, 36'h000000077, 52'h7777); cyc();
        do_lkp(36'h5A5A5A5A5, 28'h1); cyc();
        do_lkp(36'h000000077, 28'h2); cyc();

        // R6: duplicate insert moves the ESID
        cur_tag = "R6"; do_wr(5'd12, 36'h000000001, 52'hBEEF); cyc();
        do_lkp(36'h000000001, 28'h33); cyc();
        do_wr(5'd0, 36'h000000099, 52'h99); cyc();
        do_lkp(36'h000000001, 28'h44); cyc();

        // R10: lookup alongside a write sees old table
        cur_tag = "R10"; do_wr(5'd3, 36'h000000AAA, 52'hAAA); do_lkp(36'h000000AAA, 28'h1); cyc();
        do_lkp(36'h000000AAA, 28'h1); cyc();
        do_wr(5'd3, 36'h000000BBB, 52'hBBB); do_lkp(36'h000000AAA, 28'h2); cyc();

        // R8 / R7: lookup with flush misses, table empty afterwards
        cur_tag = "R8"; do_lkp(36'h000000BBB, 28'h3); flush = 1'b1; cyc();
        cur_tag = "R7"; do_lkp(36'hFFFFFFFFF, 28'h0); cyc();
        do_lkp(36'h000000001, 28'h0); cyc();

        // R9: write with flush is dropped
        cur_tag = "R9"; do_wr(5'd9, 36'h000000CCC, 52'hCCC); flush = 1'b1; cyc();
        do_lkp(36'h000000CCC, 28'h9); cyc();

        // Random mix over a small ESID pool
        cur_tag = "R6";
        for (int n = 0; n < 3000; n++) begin
            if ($urandom_range(0, 2) != 0)
                do_lkp(36'($urandom_range(0, 11)), 28'($urandom));
            if ($urandom_range(0, 2) == 0)
                do_wr(5'($urandom_range(0, 31)), 36'($urandom_range(0, 11)),
                      {20'($urandom), 32'($urandom)});
            if ($urandom_range(0, 60) == 0) flush = 1'b1;
            cyc();
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule